// File: doc/BRIEF.md
# Small-Modulus Remainder Extractor for Residue-Coded Values

This block takes the channel residues of a large integer held in residue number system form and returns the integer's remainder modulo 4 and modulo 3. It never rebuilds the integer in binary. Every channel modulus is assumed odd and congruent to 1 modulo 12. Under that assumption each residue enters both small-modulus sums directly, and the only correction needed is the Chinese-remainder overflow count `q`.

The block estimates `q` by adding the top `T` bits of every residue, treating each group of bits as a binary fraction. It adds a fixed rounding offset to that sum and keeps the integer part. The two LSBs of each residue are summed modulo 4. Each residue's full mod-3 value, from a per-channel digit-folding reducer, is summed modulo 3. The single `q` estimate is then subtracted from both sums.

A one-cycle `in_valid` strobe captures the residues. The two remainders appear, registered, together with `out_valid` on the following cycle. The caller keeps the evaluated value in a positive range where the truncated estimate is exact, which an offset of twelve times the field prime provides. Producing the residues and any scaling of them is the caller's job.

Top module: `crt_small_rem`

## Requirements
- R1: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` was sampled high, and low otherwise. Back-to-back strobes give back-to-back results.
- R2: While `rst_n` is low, and after it is released until the first strobe, `out_valid`, `out_rem4` and `out_rem3` are all zero.
- R3: The overflow estimate is `q = floor((S + ROUND_OFS) / 2^T)`, where `S` is the sum over channels of residue bits `[W-1:W-T]`, read as unsigned integers. Channel `i` occupies `in_res[i*W +: W]`.
- R4: `out_rem4 = (Σ(r_i mod 4) − q) mod 4`, where `r_i mod 4` is the residue's two LSBs.
- R5: `out_rem3 = (Σ(r_i mod 3) − q) mod 3`, where `r_i mod 3` is taken over the full W-bit residue.
- R6: `out_rem3` is always 0, 1 or 2 and never the code 3.
- R7: In cycles with `in_valid` low, changes on `in_res` have no effect: `out_rem4` and `out_rem3` keep the last result.
- R8: The result does not depend on the order of the channels. Permuting the residues among the channels gives the same remainders.
- R9: The estimate `q` never exceeds `N_CH` when `ROUND_OFS < 2^T`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe: capture `in_res` this cycle |
| in_res | input | N_CH*W | Channel residues, channel i at bits [i*W +: W] |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_rem4 | output | 2 | Value modulo 4 |
| out_rem3 | output | 2 | Value modulo 3 |

## Verification
The bench aims at the exact threshold where the summed top bits plus the offset reach a multiple of 2^T. A design that drops the rounding offset, or shifts by the wrong amount, gives a `q` that is off by one, and that shows up as wrong remainders on both outputs. All-ones residues check that the mod-3 reducer folds every digit pair and corrects 3 down to 0. A reducer that looks only at the low bits, or that skips the final correction, gives the wrong `out_rem3` or the illegal code 3. The bench also runs back-to-back strobes, input changes while the strobe is idle, and permuted channels. These catch a valid pipeline that stretches or drops pulses, outputs that follow the inputs without a strobe, and a channel slice that has been wired up unevenly.

// File: rtl/crt_small_rem_pkg.sv
package crt_small_rem_pkg;

  // Residue of a 32-bit value modulo 3: 4 == 1 (mod 3), so summing the
  // 2-bit digits keeps the residue; five passes shrink any value to 0..3.
  function automatic logic [1:0] mod3_fold32(input logic [31:0] v);
    logic [31:0] s;
    logic [31:0] t;
    s = v;
    for (int p = 0; p < 5; p++) begin
      t = '0;
      for (int d = 0; d < 16; d++) begin
        t = t + {30'b0, s[2*d +: 2]};
      end
      s = t;
    end
    return (s[1:0] == 2'd3) ? 2'd0 : s[1:0];
  endfunction

  // Modular difference (a - b) mod 3 for a, b already in 0..2.
  function automatic logic [1:0] sub_mod3(input logic [1:0] a, input logic [1:0] b);
    logic [2:0] d;
    d = {1'b0, a} + 3'd3 - {1'b0, b};
    return (d >= 3'd3) ? 2'(d - 3'd3) : d[1:0];
  endfunction

endpackage

// File: rtl/crt_chan_slice.sv
module crt_chan_slice
  import crt_small_rem_pkg::*;
#(
  parameter int W = 16,
  parameter int T = 6
) (
  input  logic [W-1:0] res,
  output logic [T-1:0] top_bits,
  output logic [1:0]   lo2,
  output logic [1:0]   m3
);
  assign top_bits = res[W-1 -: T];
  assign lo2      = res[1:0];
  assign m3       = mod3_fold32(32'(res));
endmodule

// File: rtl/crt_rem_combine.sv
module crt_rem_combine
  import crt_small_rem_pkg::*;
#(
  parameter int N_CH      = 4,
  parameter int T         = 6,
  parameter int ROUND_OFS = 2,
  localparam int QW       = $clog2(N_CH + 1) + 1,
  localparam int SUMW     = T + QW
) (
  input  logic [N_CH*T-1:0] tops,
  input  logic [N_CH*2-1:0] lo2s,
  input  logic [N_CH*2-1:0] m3s,
  output logic [QW-1:0]     q_est,
  output logic [1:0]        sum4,
  output logic [1:0]        sum3,
  output logic [1:0]        rem4_next,
  output logic [1:0]        rem3_next
);
  logic [SUMW-1:0] frac_sum;
  logic [31:0]     m3_acc;

  always_comb begin
    frac_sum = SUMW'(ROUND_OFS);
    sum4     = 2'd0;
    m3_acc   = '0;
    for (int i = 0; i < N_CH; i++) begin
      frac_sum = frac_sum + SUMW'(tops[i*T +: T]);
      sum4     = sum4 + lo2s[i*2 +: 2];
      m3_acc   = m3_acc + {30'b0, m3s[i*2 +: 2]};
    end
  end

  assign q_est     = frac_sum[SUMW-1 -: QW];
  assign sum3      = mod3_fold32(m3_acc);
  assign rem4_next = sum4 - q_est[1:0];
  assign rem3_next = sub_mod3(sum3, mod3_fold32(32'(q_est)));
endmodule

// File: rtl/crt_small_rem.sv
module crt_small_rem #(
  parameter int N_CH      = 4,
  parameter int W         = 16,
  parameter int T         = 6,
  parameter int ROUND_OFS = 2,
  localparam int QW       = $clog2(N_CH + 1) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [N_CH*W-1:0] in_res,
  output logic              out_valid,
  output logic [1:0]        out_rem4,
  output logic [1:0]        out_rem3
);
  logic [N_CH*T-1:0] tops_w;
  logic [N_CH*2-1:0] lo2_w;
  logic [N_CH*2-1:0] m3_w;
  logic [QW-1:0]     q_est;
  logic [1:0]        sum4_w;
  logic [1:0]        sum3_w;
  logic [1:0]        rem4_next;
  logic [1:0]        rem3_next;

  for (genvar g = 0; g < N_CH; g++) begin : g_chan
    crt_chan_slice #(.W(W), .T(T)) slice_i (
      .res      (in_res[g*W +: W]),
      .top_bits (tops_w[g*T +: T]),
      .lo2      (lo2_w[g*2 +: 2]),
      .m3       (m3_w[g*2 +: 2])
    );
  end

  crt_rem_combine #(.N_CH(N_CH), .T(T), .ROUND_OFS(ROUND_OFS)) comb_i (
    .tops      (tops_w),
    .lo2s      (lo2_w),
    .m3s       (m3_w),
    .q_est     (q_est),
    .sum4      (sum4_w),
    .sum3      (sum3_w),
    .rem4_next (rem4_next),
    .rem3_next (rem3_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rem4  <= 2'd0;
      out_rem3  <= 2'd0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_rem4 <= rem4_next;
        out_rem3 <= rem3_next;
      end
    end
  end
endmodule

// File: rtl/crt_small_rem_chk.sv
module crt_small_rem_chk #(
  parameter int N_CH = 4,
  parameter int QW   = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          out_valid,
  input logic [1:0]    out_rem4,
  input logic [1:0]    out_rem3,
  input logic [1:0]    sum3_w,
  input logic [QW-1:0] q_est
);
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r6_rem3_legal: assert property (@(posedge clk) disable iff (!rst_n)
    out_rem3 != 2'd3);
  a_r5_sum3_legal: assert property (@(posedge clk) disable iff (!rst_n)
    sum3_w != 2'd3);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_rem4) && $stable(out_rem3)));
  a_r9_q_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(q_est) <= N_CH);
endmodule

bind crt_small_rem crt_small_rem_chk #(.N_CH(N_CH), .QW(QW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_rem4  (out_rem4),
  .out_rem3  (out_rem3),
  .sum3_w    (sum3_w),
  .q_est     (q_est)
);

// File: tb/crt_small_rem_tb_top.sv
module crt_small_rem_tb_top;
  localparam int N_CH = 4;
  localparam int W    = 16;
  localparam int T    = 6;
  localparam int OFS  = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic [N_CH*W-1:0] in_res = '0;
  logic              out_valid;
  logic [1:0]        out_rem4;
  logic [1:0]        out_rem3;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  crt_small_rem #(.N_CH(N_CH), .W(W), .T(T), .ROUND_OFS(OFS)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_res(in_res),
    .out_valid(out_valid), .out_rem4(out_rem4), .out_rem3(out_rem3)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected remainders from R3..R5, written with plain integer arithmetic.
  task automatic expect_of(input logic [N_CH*W-1:0] v, output int e4, output int e3);
    int tsum, q, s4, s3, r;
    tsum = 0; s4 = 0; s3 = 0;
    for (int i = 0; i < N_CH; i++) begin
      r = int'(v[i*W +: W]);
      tsum += r / (1 << (W - T));
      s4 += r % 4;
      s3 += r % 3;
    end
    q  = (tsum + OFS) / (1 << T);
    e4 = (((s4 - q) % 4) + 4) % 4;
    e3 = (((s3 - q) % 3) + 3) % 3;
  endtask

  task automatic run_one(input string req, input logic [N_CH*W-1:0] v);
    int e4, e3;
    expect_of(v, e4, e3);
    @(negedge clk);
    in_res = v; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, int'(out_valid), 1);
    check({req, " rem4"}, int'(out_rem4), e4);
    check({req, " rem3"}, int'(out_rem3), e3);
  endtask

  function automatic logic [N_CH*W-1:0] pack4(input int a, input int b, input int c, input int d);
    return {W'(d), W'(c), W'(b), W'(a)};
  endfunction

  task automatic t_reset;
    @(negedge clk);
    check("R2 reset valid", int'(out_valid), 0);
    check("R2 reset rem4", int'(out_rem4), 0);
    check("R2 reset rem3", int'(out_rem3), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 idle after reset valid", int'(out_valid), 0);
    check("R2 idle after reset rem4", int'(out_rem4), 0);
  endtask

  task automatic t_extremes;
    run_one("R4 R5 all zero", '0);
    run_one("R4 R5 all ones", '1);                 // q=3, rem4=1, rem3=0
    check("R6 all ones rem3 legal", int'(out_rem3 != 2'd3), 1);
    @(negedge clk);
    check("R1 single pulse", int'(out_valid), 0);
  endtask

  task automatic t_q_threshold;
    // top bits 61 + OFS = 63 -> q=0 ; 62 + OFS = 64 -> q=1 (R3)
    run_one("R3 below threshold", pack4(61 << 10, 5, 7, 11));
    run_one("R3 at threshold", pack4(62 << 10, 5, 7, 11));
    run_one("R3 multi-channel carry", pack4(63 << 10, 63 << 10, 63 << 10, 1 << 10));
  endtask

  task automatic t_back_to_back;
    logic [N_CH*W-1:0] a, b;
    int a4, a3, b4, b3;
    a = pack4(16'h1234, 16'hBEEF, 16'h0F0F, 16'h8001);
    b = pack4(16'hFFFE, 16'h0003, 16'h7777, 16'hC000);
    expect_of(a, a4, a3);
    expect_of(b, b4, b3);
    @(negedge clk); in_res = a; in_valid = 1'b1;
    @(negedge clk); in_res = b;
    check("R1 b2b first valid", int'(out_valid), 1);
    check("R4 b2b first rem4", int'(out_rem4), a4);
    check("R5 b2b first rem3", int'(out_rem3), a3);
    @(negedge clk); in_valid = 1'b0;
    check("R1 b2b second valid", int'(out_valid), 1);
    check("R4 b2b second rem4", int'(out_rem4), b4);
    check("R5 b2b second rem3", int'(out_rem3), b3);
    @(negedge clk);
    check("R1 b2b end", int'(out_valid), 0);
  endtask

  task automatic t_hold;
    int h4, h3;
    run_one("R7 setup", pack4(16'hA5A5, 16'h5A5A, 16'h0102, 16'hF00D));
    h4 = int'(out_rem4); h3 = int'(out_rem3);
    for (int k = 0; k < 4; k++) begin
      in_res = pack4(k * 4099 + 17, 16'hFFFF - k, k << 12, 3 * k + 1);
      @(negedge clk);
      check("R7 hold rem4", int'(out_rem4), h4);
      check("R7 hold rem3", int'(out_rem3), h3);
      check("R7 hold valid low", int'(out_valid), 0);
    end
  endtask

  task automatic t_permute;
    int p4, p3;
    run_one("R8 order A", pack4(16'h9C41, 16'h3E07, 16'hD2D2, 16'h0455));
    p4 = int'(out_rem4); p3 = int'(out_rem3);
    run_one("R8 order B", pack4(16'h0455, 16'hD2D2, 16'h9C41, 16'h3E07));
    check("R8 same rem4", int'(out_rem4), p4);
    check("R8 same rem3", int'(out_rem3), p3);
  endtask

  task automatic t_random;
    logic [N_CH*W-1:0] v;
    for (int k = 0; k < 60; k++) begin
      for (int i = 0; i < N_CH; i++) v[i*W +: W] = W'($urandom());
      run_one("R3 R4 R5 random", v);
      check("R6 random rem3 legal", int'(out_rem3 != 2'd3), 1);
    end
  endtask

  initial begin
    t_reset();
    t_extremes();
    t_q_threshold();
    t_back_to_back();
    t_hold();
    t_permute();
    t_random();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule